// File: doc/BRIEF.md
# SPI FIFO, Interrupt and DMA Request Unit

This block sits between a register port and an SPI shift engine. It holds a transmit queue that software fills one word at a time, and a receive queue that the engine fills. It reports how full each queue is. It turns queue levels and error events into a maskable interrupt, and it asserts per-direction DMA request lines from programmable level marks. Software uses a simple word register port: a write strobe, a read strobe and a 4-bit word index. Read data comes back one cycle after the read strobe, flagged by `reg_rvalid`.

Toward the engine, the transmit side is a valid/ready source. A word stays on `tx_out_data` with `tx_out_valid` high until `tx_out_ready` takes it, so the engine may stall for as long as it needs. The receive side is a valid/ready sink that never back-pressures while the unit is enabled (`rx_in_ready` follows the enable bit). A frame that arrives at a full receive queue is dropped and flagged, not stalled. While disabled, `rx_in_ready` is low, `tx_out_valid` is low and both queues are held empty.

Register word indices: 0 enable (bit0), 1 transmit threshold, 2 receive threshold, 3 transmit level, 4 receive level, 5 status, 6 interrupt mask, 7 masked interrupt status, 8 raw interrupt status, 9 interrupt clear, 10 DMA control, 11 transmit DMA level, 12 receive DMA level, 13 transmit data (write), 14 receive data (read). With default parameters each queue holds 32 words of 16 bits.

Top module: `spi_buffer_ctl`

## Requirements
- R1: After reset both levels (indices 3, 4) read 0, status reads 0x0C, raw interrupt status reads 0x01, and `irq`, `tx_dma_req`, `rx_dma_req` and `tx_out_valid` are low.
- R2: Words written to index 13 while enabled leave on `tx_out_data` in write order, one per cycle in which `tx_out_valid` and `tx_out_ready` are both high; while ready is low the presented word holds steady.
- R3: A write to index 13 when the transmit queue holds DEPTH words is discarded, the level stays at DEPTH, and raw interrupt bit1 (transmit overflow) becomes set and stays set.
- R4: Index 3 and index 4 return the current word counts of the two queues; reads of index 14 return received words oldest first and each read removes one word.
- R5: While enabled `rx_in_ready` is high; a frame offered when the receive queue holds DEPTH words is dropped, earlier words are kept, and raw bit3 (receive overflow) becomes set.
- R6: A read of index 14 with the receive queue empty returns 0 and sets raw bit2 (receive underflow).
- R7: Writes to the threshold and DMA level registers (indices 1, 2, 11, 12) with a value of DEPTH or more are ignored, so the register keeps its last accepted value; accepted values read back unchanged.
- R8: Raw bit0 is high while transmit level is at most the transmit threshold; raw bit4 is high while receive level is above the receive threshold.
- R9: Index 7 reads raw status ANDed with the mask at index 6, and `irq` is high exactly when any masked bit is high.
- R10: Writing index 9 with bit0 set clears raw bits 1, 2 and 3; bit1 clears bit2 only, bit2 clears bit3 only, bit3 clears bit1 only. An event in the same cycle as its clear keeps the bit set.
- R11: Status bits are bit0 busy (`eng_busy` or `tx_out_valid`), bit1 transmit full, bit2 transmit empty, bit3 receive empty, bit4 receive full.
- R12: With DMA control (index 10) bit1 set and enable on, `tx_dma_req` is high while transmit level is at most index 11; with bit0 set, `rx_dma_req` is high while receive level exceeds index 12.
- R13: Writing 0 to enable empties both queues, both levels read 0, and `rx_in_ready` and `tx_out_valid` go low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| tx_out_valid | output | 1 | Transmit word available to engine |
| tx_out_ready | input | 1 | Engine takes transmit word |
| tx_out_data | output | 16 | Transmit word |
| rx_in_valid | input | 1 | Engine offers a received frame |
| rx_in_ready | output | 1 | Frame accepted (equals enable) |
| rx_in_data | input | 16 | Received frame |
| eng_busy | input | 1 | Engine shifting indication |
| irq | output | 1 | Combined masked interrupt |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |

## Verification
The assertions assume that enable changes only through a register write and that at most one register write occurs per cycle. This is why a full transmit queue cannot be flushed and refilled in the same cycle that an overflow write is checked. They make no assumption about when `rx_in_valid` or `tx_out_ready` toggle. The stimulus performs one register access at a time, offers received frames as single-cycle pulses, and raises `tx_out_ready` only in stretches between register accesses, so each register read observes a settled queue.

// File: rtl/spibuf_pkg.sv
`timescale 1ns/1ps
package spibuf_pkg;
  typedef enum logic [3:0] {
    RG_ENABLE  = 4'd0,
    RG_TX_THR  = 4'd1,
    RG_RX_THR  = 4'd2,
    RG_TX_LVL  = 4'd3,
    RG_RX_LVL  = 4'd4,
    RG_STATUS  = 4'd5,
    RG_IMASK   = 4'd6,
    RG_IMSTAT  = 4'd7,
    RG_IRAW    = 4'd8,
    RG_ICLR    = 4'd9,
    RG_DMACTL  = 4'd10,
    RG_TX_DLVL = 4'd11,
    RG_RX_DLVL = 4'd12,
    RG_TXDATA  = 4'd13,
    RG_RXDATA  = 4'd14
  } reg_idx_e;

  localparam int NIRQ     = 5;
  localparam int EV_TXLOW = 0;
  localparam int EV_TXOVF = 1;
  localparam int EV_RXUNF = 2;
  localparam int EV_RXOVF = 3;
  localparam int EV_RXHI  = 4;
endpackage

// File: rtl/spibuf_fifo.sv
`timescale 1ns/1ps
module spibuf_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          drop,
  output logic          starve
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign drop    = push && full && !flush;
  assign starve  = pop && empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/spibuf_irq.sv
`timescale 1ns/1ps
module spibuf_irq
  import spibuf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_txovf,
  input  logic            ev_rxunf,
  input  logic            ev_rxovf,
  input  logic            lvl_txlow,
  input  logic            lvl_rxhi,
  input  logic            clr_we,
  input  logic [3:0]      clr_bits,
  input  logic [NIRQ-1:0] mask,
  output logic [NIRQ-1:0] raw,
  output logic [NIRQ-1:0] masked,
  output logic            irq
);
  logic st_txovf, st_rxunf, st_rxovf;
  logic kill_txovf, kill_rxunf, kill_rxovf;

  assign kill_txovf = clr_we && (clr_bits[0] || clr_bits[3]);
  assign kill_rxunf = clr_we && (clr_bits[0] || clr_bits[1]);
  assign kill_rxovf = clr_we && (clr_bits[0] || clr_bits[2]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_txovf <= 1'b0;
      st_rxunf <= 1'b0;
      st_rxovf <= 1'b0;
    end else begin
      st_txovf <= ev_txovf || (st_txovf && !kill_txovf);
      st_rxunf <= ev_rxunf || (st_rxunf && !kill_rxunf);
      st_rxovf <= ev_rxovf || (st_rxovf && !kill_rxovf);
    end
  end

  always_comb begin
    raw           = '0;
    raw[EV_TXLOW] = lvl_txlow;
    raw[EV_TXOVF] = st_txovf;
    raw[EV_RXUNF] = st_rxunf;
    raw[EV_RXOVF] = st_rxovf;
    raw[EV_RXHI]  = lvl_rxhi;
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/spi_buffer_ctl.sv
`timescale 1ns/1ps
module spi_buffer_ctl
  import spibuf_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int RW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [3:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  output logic          reg_rvalid,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  input  logic          eng_busy,
  output logic          irq,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);
  localparam int LW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic            en_q;
  logic [LW-1:0]   tx_thr, rx_thr, tx_dlvl, rx_dlvl;
  logic [NIRQ-1:0] mask_q, raw, masked;
  logic [1:0]      dmactl;
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic [DW-1:0]   rx_head;
  logic            tx_drop, tx_starve_unused, rx_drop, rx_starve;
  logic            fits, tx_push, rx_pop, rx_push, tx_pop;
  logic [RW-1:0]   rd_mux;
  logic [4:0]      status;

  function automatic logic hit(input logic strobe, input logic [3:0] a, input reg_idx_e r);
    return strobe && (a == r);
  endfunction

  assign fits    = reg_wdata < RW'(DEPTH);
  assign tx_push = hit(reg_wr, reg_addr, RG_TXDATA);
  assign rx_pop  = hit(reg_rd, reg_addr, RG_RXDATA);
  assign rx_in_ready  = en_q;
  assign rx_push      = rx_in_valid && en_q;
  assign tx_out_valid = en_q && (tx_cnt != '0);
  assign tx_pop       = tx_out_valid && tx_out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      tx_thr  <= '0;
      rx_thr  <= '0;
      tx_dlvl <= '0;
      rx_dlvl <= '0;
      mask_q  <= '0;
      dmactl  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        RG_ENABLE:  en_q   <= reg_wdata[0];
        RG_IMASK:   mask_q <= reg_wdata[NIRQ-1:0];
        RG_DMACTL:  dmactl <= reg_wdata[1:0];
        RG_TX_THR:  if (fits) tx_thr  <= reg_wdata[LW-1:0];
        RG_RX_THR:  if (fits) rx_thr  <= reg_wdata[LW-1:0];
        RG_TX_DLVL: if (fits) tx_dlvl <= reg_wdata[LW-1:0];
        RG_RX_DLVL: if (fits) rx_dlvl <= reg_wdata[LW-1:0];
        default: ;
      endcase
    end
  end

  spibuf_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(!en_q),
    .push(tx_push), .push_data(reg_wdata[DW-1:0]), .pop(tx_pop),
    .head(tx_out_data), .count(tx_cnt), .drop(tx_drop), .starve(tx_starve_unused)
  );

  spibuf_fifo #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(!en_q),
    .push(rx_push), .push_data(rx_in_data), .pop(rx_pop),
    .head(rx_head), .count(rx_cnt), .drop(rx_drop), .starve(rx_starve)
  );

  spibuf_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .ev_txovf(tx_drop), .ev_rxunf(rx_starve), .ev_rxovf(rx_drop),
    .lvl_txlow(tx_cnt <= CW'(tx_thr)), .lvl_rxhi(rx_cnt > CW'(rx_thr)),
    .clr_we(hit(reg_wr, reg_addr, RG_ICLR)), .clr_bits(reg_wdata[3:0]),
    .mask(mask_q), .raw(raw), .masked(masked), .irq(irq)
  );

  assign tx_dma_req = en_q && dmactl[1] && (tx_cnt <= CW'(tx_dlvl));
  assign rx_dma_req = en_q && dmactl[0] && (rx_cnt >  CW'(rx_dlvl));

  assign status = {rx_cnt == CW'(DEPTH), rx_cnt == '0, tx_cnt == '0,
                   tx_cnt == CW'(DEPTH), eng_busy || tx_out_valid};

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      RG_ENABLE:  rd_mux = RW'(en_q);
      RG_TX_THR:  rd_mux = RW'(tx_thr);
      RG_RX_THR:  rd_mux = RW'(rx_thr);
      RG_TX_LVL:  rd_mux = RW'(tx_cnt);
      RG_RX_LVL:  rd_mux = RW'(rx_cnt);
      RG_STATUS:  rd_mux = RW'(status);
      RG_IMASK:   rd_mux = RW'(mask_q);
      RG_IMSTAT:  rd_mux = RW'(masked);
      RG_IRAW:    rd_mux = RW'(raw);
      RG_DMACTL:  rd_mux = RW'(dmactl);
      RG_TX_DLVL: rd_mux = RW'(tx_dlvl);
      RG_RX_DLVL: rd_mux = RW'(rx_dlvl);
      RG_RXDATA:  rd_mux = (rx_cnt != '0) ? RW'(rx_head) : '0;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/spibuf_chk.sv
`timescale 1ns/1ps
module spibuf_chk #(
  parameter int DEPTH = 32,
  parameter int DW    = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic [DW-1:0] tx_out_data,
  input logic          rx_in_valid,
  input logic          rx_in_ready,
  input logic          reg_wr,
  input logic [3:0]    reg_addr,
  input logic [4:0]    raw,
  input logic [4:0]    mask_q,
  input logic          irq,
  input logic          tx_dma_req,
  input logic          rx_dma_req
);
  assert_tx_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready && en_q) |=> (!en_q || (tx_out_valid && $stable(tx_out_data))));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && reg_wr && reg_addr == 4'd13 && tx_cnt == CW'(DEPTH) && !(tx_out_valid && tx_out_ready))
      |=> (tx_cnt == CW'(DEPTH)));

  assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

  assert_rx_drop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_in_valid && rx_in_ready && rx_cnt == CW'(DEPTH)) |=> raw[3] && rx_cnt == CW'(DEPTH));

  assert_mask_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);

  assert_dma_sane_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dma_req |-> rx_cnt != '0) and (tx_dma_req |-> en_q));

  assert_flush_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && $past(!en_q)) |-> (tx_cnt == '0 && rx_cnt == '0 && !rx_in_ready));
endmodule

bind spi_buffer_ctl spibuf_chk #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
  .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
  .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .raw(raw), .mask_q(mask_q), .irq(irq),
  .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
);

// File: tb/spi_buffer_ctl_test.sv
`timescale 1ns/1ps
module spi_buffer_ctl_test;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        reg_rvalid;
  logic        tx_out_valid, tx_out_ready = 1'b0;
  logic [15:0] tx_out_data;
  logic        rx_in_valid = 1'b0, rx_in_ready;
  logic [15:0] rx_in_data = '0;
  logic        eng_busy = 1'b0, irq, tx_dma_req, rx_dma_req;

  int n_chk = 0, n_bad = 0;
  logic [15:0] exp_q [$];
  logic [31:0] v;

  always #2.5 clk = ~clk;

  spi_buffer_ctl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .eng_busy(eng_busy), .irq(irq), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk); #1;
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic send_tx(input logic [15:0] w, input bit expect_out);
    if (expect_out) exp_q.push_back(w);
    wr(4'd13, {16'h0, w});
  endtask

  task automatic push_rx(input logic [15:0] w);
    @(posedge clk); #1;
    rx_in_valid = 1'b1; rx_in_data = w;
    @(posedge clk); #1;
    rx_in_valid = 1'b0;
  endtask

  task automatic drain(input int cycles);
    @(posedge clk); #1;
    tx_out_ready = 1'b1;
    repeat (cycles) @(posedge clk);
    #1 tx_out_ready = 1'b0;
  endtask

  // scoreboard monitor: every handshake on the transmit stream is compared
  always @(negedge clk) begin
    if (rst_n && tx_out_valid && tx_out_ready) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R2 stream word actual=%0h expected=none", tx_out_data);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        if (tx_out_data !== e) begin
          n_bad++;
          $display("FAIL R2 stream order actual=%0h expected=%0h", tx_out_data, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 irq", irq, 0);
    chk("R1 dma", {tx_dma_req, rx_dma_req, tx_out_valid}, 0);
    rd(4'd5, v); chk("R1 R11 status", v, 32'h0C);
    rd(4'd8, v); chk("R1 R8 raw", v, 32'h01);
    rd(4'd3, v); chk("R1 tx level", v, 0);

    // R7: threshold write filter
    wr(4'd1, 31); rd(4'd1, v); chk("R7 accept 31", v, 31);
    wr(4'd1, 32); rd(4'd1, v); chk("R7 reject 32", v, 31);
    wr(4'd1, 3);  rd(4'd1, v); chk("R7 accept 3", v, 3);
    wr(4'd2, 2);

    wr(4'd0, 1);
    for (int i = 0; i < 4; i++) send_tx(16'hA000 + 16'(i), 1'b1);
    rd(4'd3, v); chk("R4 tx level 4", v, 4);
    rd(4'd5, v); chk("R11 status busy", v, 32'h09);
    rd(4'd8, v); chk("R8 above tx thr", v, 32'h00);
    chk("R2 valid held", tx_out_valid, 1);
    drain(6);
    rd(4'd3, v); chk("R2 drained", v, 0);

    // R3: overflow of the transmit queue
    for (int i = 0; i < DEPTH + 1; i++) send_tx(16'h5000 + 16'(i), i < DEPTH);
    rd(4'd3, v); chk("R3 level capped", v, DEPTH);
    rd(4'd5, v); chk("R11 status tx full", v, 32'h0B);
    rd(4'd8, v); chk("R3 raw ovf", v, 32'h02);
    drain(DEPTH + 8);
    chk("R3 dropped word absent", exp_q.size(), 0);
    rd(4'd8, v); chk("R8 tx low again", v, 32'h03);

    // R4 / R6: receive path
    for (int i = 0; i < 3; i++) push_rx(16'hB000 + 16'(i));
    rd(4'd4, v); chk("R4 rx level", v, 3);
    rd(4'd8, v); chk("R8 rx above thr", v, 32'h13);
    for (int i = 0; i < 3; i++) begin
      rd(4'd14, v); chk("R4 rx data", v, 32'hB000 + i);
    end
    rd(4'd14, v); chk("R6 empty read zero", v, 0);
    rd(4'd8, v); chk("R6 underflow flag", v, 32'h07);

    // R5: receive overflow
    chk("R5 ready", rx_in_ready, 1);
    for (int i = 0; i < DEPTH + 1; i++) push_rx(16'hC000 + 16'(i));
    rd(4'd4, v); chk("R5 rx level capped", v, DEPTH);
    rd(4'd5, v); chk("R11 status rx full", v, 32'h14);
    rd(4'd8, v); chk("R5 raw all", v, 32'h1F);
    rd(4'd14, v); chk("R5 oldest kept", v, 32'hC000);

    // R9 / R10: mask and clear
    wr(4'd6, 32'h08);
    chk("R9 irq on", irq, 1);
    rd(4'd7, v); chk("R9 masked", v, 32'h08);
    wr(4'd9, 32'h04);
    chk("R10 irq off", irq, 0);
    rd(4'd8, v); chk("R10 selective clear", v, 32'h17);
    wr(4'd9, 32'h01);
    rd(4'd8, v); chk("R10 clear all", v, 32'h11);

    // R12: DMA requests (rx level 31 now)
    wr(4'd12, 30); wr(4'd10, 1);
    chk("R12 rx req on", {rx_dma_req, tx_dma_req}, 2'b10);
    wr(4'd12, 31);
    chk("R12 rx req off", rx_dma_req, 0);
    wr(4'd11, 0); wr(4'd10, 3);
    chk("R12 tx req on", tx_dma_req, 1);
    send_tx(16'hDEAD, 1'b0);
    chk("R12 tx req off", tx_dma_req, 0);

    // R13: disable flushes
    wr(4'd0, 0);
    rd(4'd3, v); chk("R13 tx flushed", v, 0);
    rd(4'd4, v); chk("R13 rx flushed", v, 0);
    chk("R13 stream idle", {rx_in_ready, tx_out_valid, tx_dma_req, rx_dma_req}, 0);
    chk("R2 scoreboard empty", exp_q.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule